// File: doc/BRIEF.md
# Set-Associative Translation Buffer with Command Registers

This block holds page translations that software installs and maintains by hand. Each entry pairs a virtual page number and an 8-bit address-space tag with a physical frame number and three kernel permission bits (execute, write, read). Software reaches the array through three registers, a tag word, a frame word and an index word, and through a command strobe. The commands are: search for a page, choose a slot, store the registers into a slot, load a slot into the registers, and clear a slot. Every command finishes in the clock edge that accepts it.

A second path serves hardware translation. A request carries a virtual address and an address-space tag. One cycle later the block answers with hit, frame and permissions. It also raises an overlap flag when more than one way of the addressed set matches. The answer moves over a valid/ready pair. The request side stalls while an answer is waiting to be taken. Entries are numbered linearly so that all ways of one set come before the next set. The set is chosen by the low bits of the virtual page number.

Top module: `sa_xlate_buffer`

## Requirements
- R1: After reset the tag, frame and index words read zero, every entry is invalid, `lk_rsp_valid` is 0 and `lk_req_ready` is 1.
- R2: With no command in the same cycle, `reg_wr_en` loads `reg_wr_data` into the tag word (sel 0), frame word (sel 1) or index word (sel 2), visible one cycle later. When a command is also issued in that cycle, the register write is dropped.
- R3: Command op 0 (probe) searches the set of the tag word's page. On a hit it loads the index word with `set*WAYS+way`, using the lowest matching way, and bit 31 clear. On a miss it loads 0x8000_0000 (bit 31 is the lookup-error flag).
- R4: An entry matches when its valid bit is set, its page number equals the requested one, and either its global bit is set or its address-space tag equals the requested one.
- R5: Command op 1 (get index) loads the index word with `set*WAYS+way` of the lowest invalid way in the tag word's set, bit 31 clear. If every way is valid it uses that set's round-robin pointer, which then advances by one (modulo WAYS). The pointer moves only when it is used.
- R6: Command op 2 (write) stores the registers into the entry at index bits [IDX_W-1:0] when index bit 31 is clear, and changes nothing when it is set. The fields stored are: page number from tag bits [31:13], valid from bit 10, global from bit 8, address-space tag from bits [7:0], frame from frame bits [31:13], and permissions from frame bits [2:0]. The write replaces an existing entry at that slot. Storing a duplicate page raises no flag.
- R7: Command op 3 (read) loads the tag and frame words from the indexed entry, in the R6 layout with all other bits zero.
- R8: A lookup is accepted when `lk_req_valid` and `lk_req_ready` are both high, where `lk_req_ready` = `!lk_rsp_valid || lk_rsp_ready`. The answer is valid the next cycle and holds unchanged until `lk_rsp_ready` takes it.
- R9: A lookup answer gives hit, frame and permissions of the lowest matching way. On a miss, hit, frame and permissions are all zero.
- R10: When two or more ways of the set match a lookup, `lk_rsp_overlap` is 1 and hit is 1.
- R11: Command op 4 (erase) writes zeros to the indexed entry when index bit 31 is clear. The entry then reads back as zero and never matches. Ops 5 to 7 have no effect.
- R12: A lookup sees the array as it stood before any command accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | 0 tag, 1 frame, 2 index, 3 none |
| reg_wr_data | input | 32 | Register write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| tag_q | output | 32 | Tag word |
| frame_q | output | 32 | Frame word |
| index_q | output | 32 | Index word (bit 31 lookup error) |
| lk_req_valid | input | 1 | Lookup request valid |
| lk_req_ready | output | 1 | Lookup request ready |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address-space tag |
| lk_rsp_valid | output | 1 | Lookup answer valid |
| lk_rsp_ready | input | 1 | Lookup answer taken |
| lk_rsp_hit | output | 1 | Lookup hit |
| lk_rsp_overlap | output | 1 | More than one way matched |
| lk_rsp_pfn | output | 19 | Physical frame number |
| lk_rsp_perm | output | 3 | Permissions {exec, write, read} |

## Verification
Every cycle, the assertions hold the answer channel to its rules. An accepted request must produce an answer, and a stalled answer must not move. They also check that an overlap never appears without a hit and that get-index leaves a clear error flag and the tag word's set in the index. When a free way exists, the chosen way must be invalid. The directed scenarios are needed for the rest. They cover the exact index values of probe and round-robin replacement, overwrite through an earlier probe, read-back formatting, suppression of writes under the error flag, global-entry matching, and the ordering of a lookup against an erase in the same cycle.

// File: rtl/xb_pkg.sv
package xb_pkg;
  localparam int WORD_W     = 32;
  localparam int PAGE_SHIFT = 13;
  localparam int VPN_W      = WORD_W - PAGE_SHIFT;
  localparam int ASID_W     = 8;
  localparam int PERM_W     = 3;
  localparam int VALID_BIT  = 10;
  localparam int GLOBAL_BIT = 8;
  localparam int ERR_BIT    = WORD_W - 1;

  typedef enum logic [2:0] {
    OP_PROBE  = 3'd0,
    OP_GETIDX = 3'd1,
    OP_WRITE  = 3'd2,
    OP_READ   = 3'd3,
    OP_ERASE  = 3'd4
  } op_e;

  typedef struct packed {
    logic              valid;
    logic              glob;
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  pfn;
    logic [PERM_W-1:0] perm;
  } entry_t;
endpackage

// File: rtl/xb_store.sv
module xb_store
  import xb_pkg::*;
#(
  parameter int SETS = 128,
  parameter int WAYS = 2,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int IDX_W = SET_W + WAY_W,
  localparam int ENTRIES = SETS * WAYS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SET_W-1:0]       set_a,
  output entry_t [WAYS-1:0]      ent_a,
  output logic [WAY_W-1:0]       rr_ptr_a,
  input  logic [SET_W-1:0]       set_b,
  output entry_t [WAYS-1:0]      ent_b,
  input  logic [IDX_W-1:0]       rd_idx,
  output entry_t                 ent_rd,
  input  logic                   we,
  input  logic [IDX_W-1:0]       wr_idx,
  input  entry_t                 wr_ent,
  input  logic                   rr_adv,
  input  logic [SET_W-1:0]       rr_set
);
  entry_t           mem  [ENTRIES];
  logic [WAY_W-1:0] rr_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else begin
      if (we) mem[wr_idx] <= wr_ent;
      if (rr_adv) rr_q[rr_set] <= rr_q[rr_set] + WAY_W'(1);
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign ent_a[w] = mem[{set_a, WAY_W'(w)}];
    assign ent_b[w] = mem[{set_b, WAY_W'(w)}];
  end

  assign ent_rd   = mem[rd_idx];
  assign rr_ptr_a = rr_q[set_a];
endmodule

// File: rtl/xb_match.sv
module xb_match
  import xb_pkg::*;
#(
  parameter int WAYS = 2,
  localparam int WAY_W = $clog2(WAYS),
  localparam int CNT_W = $clog2(WAYS + 1)
) (
  input  entry_t [WAYS-1:0]  ents,
  input  logic [VPN_W-1:0]   vpn,
  input  logic [ASID_W-1:0]  asid,
  output logic               hit_any,
  output logic [WAY_W-1:0]   hit_way,
  output logic               hit_multi
);
  logic [WAYS-1:0] hit;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit[w] = ents[w].valid && (ents[w].vpn == vpn) &&
                    (ents[w].glob || (ents[w].asid == asid));
  end

  logic [CNT_W-1:0] n_hit;

  always_comb begin
    hit_way = '0;
    n_hit   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit[w]) hit_way = WAY_W'(w);
    end
    for (int w = 0; w < WAYS; w++) begin
      n_hit = n_hit + CNT_W'(hit[w]);
    end
  end

  assign hit_any   = |hit;
  assign hit_multi = (n_hit > CNT_W'(1));
endmodule

// File: rtl/xb_victim.sv
module xb_victim #(
  parameter int WAYS = 2,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  valid_vec,
  input  logic [WAY_W-1:0] rr_ptr,
  output logic [WAY_W-1:0] way,
  output logic             use_rr
);
  always_comb begin
    way = rr_ptr;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_vec[w]) way = WAY_W'(w);
    end
  end

  assign use_rr = &valid_vec;
endmodule

// File: rtl/sa_xlate_buffer.sv
module sa_xlate_buffer
  import xb_pkg::*;
#(
  parameter int SETS = 128,
  parameter int WAYS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_wr_sel,
  input  logic [31:0]       reg_wr_data,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  output logic [31:0]       tag_q,
  output logic [31:0]       frame_q,
  output logic [31:0]       index_q,
  input  logic              lk_req_valid,
  output logic              lk_req_ready,
  input  logic [31:0]       lk_va,
  input  logic [7:0]        lk_asid,
  output logic              lk_rsp_valid,
  input  logic              lk_rsp_ready,
  output logic              lk_rsp_hit,
  output logic              lk_rsp_overlap,
  output logic [18:0]       lk_rsp_pfn,
  output logic [2:0]        lk_rsp_perm
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int IDX_W = SET_W + WAY_W;
  localparam logic [WORD_W-1:0] ERR_WORD = {1'b1, {(WORD_W-1){1'b0}}};

  logic [WORD_W-1:0] tag_r, frame_r, index_r;
  logic [WORD_W-1:0] tag_n, frame_n, index_n;

  // Fields of the staged tag word
  logic [VPN_W-1:0]  t_vpn;
  logic [ASID_W-1:0] t_asid;
  logic [SET_W-1:0]  t_set;
  assign t_vpn  = tag_r[WORD_W-1:PAGE_SHIFT];
  assign t_asid = tag_r[ASID_W-1:0];
  assign t_set  = t_vpn[SET_W-1:0];

  // Lookup fields
  logic [VPN_W-1:0] l_vpn;
  logic [SET_W-1:0] l_set;
  assign l_vpn = lk_va[WORD_W-1:PAGE_SHIFT];
  assign l_set = l_vpn[SET_W-1:0];

  entry_t [WAYS-1:0] ent_a, ent_b;
  entry_t            ent_rd, wr_ent, staged_ent;
  logic [WAY_W-1:0]  rr_ptr_a;
  logic              we, rr_adv;
  logic [IDX_W-1:0]  wr_idx;

  xb_store #(.SETS(SETS), .WAYS(WAYS)) store_i (
    .clk(clk), .rst_n(rst_n),
    .set_a(t_set), .ent_a(ent_a), .rr_ptr_a(rr_ptr_a),
    .set_b(l_set), .ent_b(ent_b),
    .rd_idx(index_r[IDX_W-1:0]), .ent_rd(ent_rd),
    .we(we), .wr_idx(wr_idx), .wr_ent(wr_ent),
    .rr_adv(rr_adv), .rr_set(t_set)
  );

  logic             pr_any, pr_multi;
  logic [WAY_W-1:0] pr_way;

  xb_match #(.WAYS(WAYS)) probe_match_i (
    .ents(ent_a), .vpn(t_vpn), .asid(t_asid),
    .hit_any(pr_any), .hit_way(pr_way), .hit_multi(pr_multi)
  );

  logic             lm_any, lm_multi;
  logic [WAY_W-1:0] lm_way;

  xb_match #(.WAYS(WAYS)) lookup_match_i (
    .ents(ent_b), .vpn(l_vpn), .asid(lk_asid),
    .hit_any(lm_any), .hit_way(lm_way), .hit_multi(lm_multi)
  );

  logic [WAYS-1:0]  valid_a;
  logic [WAY_W-1:0] vic_way;
  logic             vic_rr;

  for (genvar w = 0; w < WAYS; w++) begin : g_valid
    assign valid_a[w] = ent_a[w].valid;
  end

  xb_victim #(.WAYS(WAYS)) victim_i (
    .valid_vec(valid_a), .rr_ptr(rr_ptr_a), .way(vic_way), .use_rr(vic_rr)
  );

  // Entry built from the staged registers
  always_comb begin
    staged_ent       = '0;
    staged_ent.valid = tag_r[VALID_BIT];
    staged_ent.glob  = tag_r[GLOBAL_BIT];
    staged_ent.vpn   = t_vpn;
    staged_ent.asid  = t_asid;
    staged_ent.pfn   = frame_r[WORD_W-1:PAGE_SHIFT];
    staged_ent.perm  = frame_r[PERM_W-1:0];
  end

  // Command decode; a command pre-empts a register write
  always_comb begin
    tag_n   = tag_r;
    frame_n = frame_r;
    index_n = index_r;
    we      = 1'b0;
    wr_idx  = index_r[IDX_W-1:0];
    wr_ent  = '0;
    rr_adv  = 1'b0;
    if (cmd_valid) begin
      case (cmd_op)
        OP_PROBE:  index_n = pr_any ? WORD_W'({t_set, pr_way}) : ERR_WORD;
        OP_GETIDX: begin
          index_n = WORD_W'({t_set, vic_way});
          rr_adv  = vic_rr;
        end
        OP_WRITE: begin
          we     = !index_r[ERR_BIT];
          wr_ent = staged_ent;
        end
        OP_READ: begin
          tag_n = '0;
          tag_n[WORD_W-1:PAGE_SHIFT] = ent_rd.vpn;
          tag_n[VALID_BIT]           = ent_rd.valid;
          tag_n[GLOBAL_BIT]          = ent_rd.glob;
          tag_n[ASID_W-1:0]          = ent_rd.asid;
          frame_n = '0;
          frame_n[WORD_W-1:PAGE_SHIFT] = ent_rd.pfn;
          frame_n[PERM_W-1:0]          = ent_rd.perm;
        end
        OP_ERASE: we = !index_r[ERR_BIT];
        default: ;
      endcase
    end else if (reg_wr_en) begin
      case (reg_wr_sel)
        2'd0:    tag_n   = reg_wr_data;
        2'd1:    frame_n = reg_wr_data;
        2'd2:    index_n = reg_wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_r   <= '0;
      frame_r <= '0;
      index_r <= '0;
    end else begin
      tag_r   <= tag_n;
      frame_r <= frame_n;
      index_r <= index_n;
    end
  end

  assign tag_q   = tag_r;
  assign frame_q = frame_r;
  assign index_q = index_r;

  // Lookup answer stage with one-deep hold
  logic              rsp_v, rsp_hit, rsp_ovl;
  logic [VPN_W-1:0]  rsp_pfn;
  logic [PERM_W-1:0] rsp_perm;
  logic              lk_take;

  assign lk_req_ready = !rsp_v || lk_rsp_ready;
  assign lk_take      = lk_req_valid && lk_req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v    <= 1'b0;
      rsp_hit  <= 1'b0;
      rsp_ovl  <= 1'b0;
      rsp_pfn  <= '0;
      rsp_perm <= '0;
    end else if (lk_take) begin
      rsp_v    <= 1'b1;
      rsp_hit  <= lm_any;
      rsp_ovl  <= lm_multi;
      rsp_pfn  <= lm_any ? ent_b[lm_way].pfn  : '0;
      rsp_perm <= lm_any ? ent_b[lm_way].perm : '0;
    end else if (lk_rsp_ready) begin
      rsp_v <= 1'b0;
    end
  end

  assign lk_rsp_valid   = rsp_v;
  assign lk_rsp_hit     = rsp_hit;
  assign lk_rsp_overlap = rsp_ovl;
  assign lk_rsp_pfn     = rsp_pfn;
  assign lk_rsp_perm    = rsp_perm;

  wire unused_bits = ^{tag_r[PAGE_SHIFT-1:VALID_BIT+1], tag_r[GLOBAL_BIT+1],
                       frame_r[PAGE_SHIFT-1:PERM_W], lk_va[PAGE_SHIFT-1:0],
                       index_r[WORD_W-2:IDX_W]};

  // Answer channel rules
  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_v && !lk_rsp_ready |=> rsp_v && $stable(rsp_pfn) && $stable(rsp_hit)
                               && $stable(rsp_perm) && $stable(rsp_ovl));
  assert_accept_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_take |=> rsp_v);
  assert_overlap_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_v && rsp_ovl |-> rsp_hit);
  assert_probe_multi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pr_multi |-> pr_any);
  assert_getidx_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_GETIDX |=>
      !index_r[ERR_BIT] && index_r[IDX_W-1:WAY_W] == $past(t_set));
  assert_victim_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_GETIDX && !vic_rr |-> !valid_a[vic_way]);
endmodule

// File: tb/sa_xlate_buffer_tb_top.sv
`timescale 1ns/1ps
module sa_xlate_buffer_tb_top;
  localparam int WAYS = 2;
  localparam logic [2:0] PROBE = 3'd0, GETIDX = 3'd1, WRITE = 3'd2,
                         READ = 3'd3, ERASE = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        reg_wr_en = 0, cmd_valid = 0, lk_req_valid = 0, lk_rsp_ready = 1;
  logic [1:0]  reg_wr_sel = 0;
  logic [31:0] reg_wr_data = 0, lk_va = 0;
  logic [2:0]  cmd_op = 0;
  logic [7:0]  lk_asid = 0;
  logic [31:0] tag_q, frame_q, index_q;
  logic        lk_req_ready, lk_rsp_valid, lk_rsp_hit, lk_rsp_overlap;
  logic [18:0] lk_rsp_pfn;
  logic [2:0]  lk_rsp_perm;

  sa_xlate_buffer #(.SETS(128), .WAYS(WAYS)) dut_i (.*);

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] tagw(input logic [18:0] vpn, input bit g, input logic [7:0] asid);
    return {vpn, 13'b0} | 32'h400 | (g ? 32'h100 : 32'h0) | {24'b0, asid};
  endfunction
  function automatic logic [31:0] frmw(input logic [18:0] pfn, input logic [2:0] perm);
    return {pfn, 13'b0} | {29'b0, perm};
  endfunction
  function automatic logic [18:0] vp(input int hi, input int set);
    return 19'((hi << 7) | set);
  endfunction

  task automatic regw(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); reg_wr_en = 1; reg_wr_sel = sel; reg_wr_data = d;
    @(negedge clk); reg_wr_en = 0;
  endtask
  task automatic cmd(input logic [2:0] op);
    @(negedge clk); cmd_valid = 1; cmd_op = op;
    @(negedge clk); cmd_valid = 0;
  endtask
  task automatic lookup(input logic [18:0] vpn, input logic [7:0] asid,
                        output logic h, output logic [18:0] pfn,
                        output logic [2:0] perm, output logic ovl);
    @(negedge clk); lk_req_valid = 1; lk_va = {vpn, 13'h1abc}; lk_asid = asid; lk_rsp_ready = 1;
    @(negedge clk); lk_req_valid = 0;
    chk("R8 rsp valid", 32'(lk_rsp_valid), 32'd1);
    h = lk_rsp_hit; pfn = lk_rsp_pfn; perm = lk_rsp_perm; ovl = lk_rsp_overlap;
  endtask
  task automatic install(input logic [31:0] t, input logic [31:0] f, input int exp_idx, input string req);
    regw(2'd0, t); regw(2'd1, f); cmd(GETIDX);
    chk(req, index_q, 32'(exp_idx));
    cmd(WRITE);
  endtask

  logic h, o; logic [18:0] p; logic [2:0] pm;

  task automatic t_reset();
    chk("R1 tag", tag_q, 0); chk("R1 frame", frame_q, 0); chk("R1 index", index_q, 0);
    chk("R1 rsp_valid", 32'(lk_rsp_valid), 0); chk("R1 req_ready", 32'(lk_req_ready), 1);
    lookup(vp(5, 3), 8'd5, h, p, pm, o);
    chk("R1 empty miss", 32'(h), 0);
  endtask

  task automatic t_regs();
    regw(2'd0, 32'h1234_5678); chk("R2 tag write", tag_q, 32'h1234_5678);
    regw(2'd2, 32'd5);         chk("R2 index write", index_q, 32'd5);
    regw(2'd3, 32'hFFFF_FFFF); chk("R2 sel3 no effect", index_q, 32'd5);
    @(negedge clk); reg_wr_en = 1; reg_wr_sel = 0; reg_wr_data = 32'hDEAD_BEEF;
    cmd_valid = 1; cmd_op = READ;
    @(negedge clk); reg_wr_en = 0; cmd_valid = 0;
    chk("R2 command wins, R7 empty read", tag_q, 32'h0);
  endtask

  task automatic t_install();
    install(tagw(vp(5, 3), 0, 8'd5) | 32'h200, frmw(19'h111, 3'b101) | 32'h0F0, 6, "R5 getidx free way0");
    regw(2'd0, 0); regw(2'd1, 0); cmd(READ);
    chk("R7 readback tag", tag_q, tagw(vp(5, 3), 0, 8'd5));
    chk("R7 readback frame", frame_q, frmw(19'h111, 3'b101));
  endtask

  task automatic t_probe();
    regw(2'd0, tagw(vp(5, 3), 0, 8'd5)); cmd(PROBE);
    chk("R3 probe hit", index_q, 32'd6);
    regw(2'd0, tagw(vp(5, 3), 0, 8'd6)); cmd(PROBE);
    chk("R3 R4 asid miss", index_q, 32'h8000_0000);
    regw(2'd0, tagw(vp(6, 3), 0, 8'd5)); cmd(PROBE);
    chk("R3 R4 vpn miss", index_q, 32'h8000_0000);
  endtask

  task automatic t_overwrite();
    regw(2'd0, tagw(vp(5, 3), 0, 8'd5)); regw(2'd1, frmw(19'h222, 3'b011));
    cmd(PROBE); chk("R6 probe before overwrite", index_q, 32'd6);
    cmd(WRITE); cmd(READ);
    chk("R6 overwritten frame", frame_q, frmw(19'h222, 3'b011));
    cmd(GETIDX); chk("R5 next free way1", index_q, 32'd7);
  endtask

  task automatic t_global();
    install(tagw(vp(9, 10), 1, 8'h33), frmw(19'h4AB, 3'b110), 20, "R5 getidx set10");
    lookup(vp(9, 10), 8'h77, h, p, pm, o);
    chk("R4 global hit", 32'(h), 1); chk("R9 pfn", 32'(p), 32'h4AB);
    chk("R9 perm", 32'(pm), 32'd6); chk("R10 no overlap", 32'(o), 0);
    lookup(vp(5, 3), 8'd9, h, p, pm, o);
    chk("R4 R9 miss hit", 32'(h), 0); chk("R9 miss pfn", 32'(p), 0); chk("R9 miss perm", 32'(pm), 0);
  endtask

  task automatic t_backpressure();
    @(negedge clk); lk_req_valid = 1; lk_va = {vp(9, 10), 13'h0}; lk_asid = 8'h01; lk_rsp_ready = 0;
    @(negedge clk);
    chk("R8 valid", 32'(lk_rsp_valid), 1); chk("R8 ready low", 32'(lk_req_ready), 0);
    lk_va = {vp(5, 3), 13'h0}; lk_asid = 8'd5;
    @(negedge clk);
    chk("R8 held pfn", 32'(lk_rsp_pfn), 32'h4AB); chk("R8 held valid", 32'(lk_rsp_valid), 1);
    lk_rsp_ready = 1;
    @(negedge clk); lk_req_valid = 0;
    chk("R8 next answer", 32'(lk_rsp_pfn), 32'h222);
    @(negedge clk);
    chk("R8 drained", 32'(lk_rsp_valid), 0);
  endtask

  task automatic t_rr();
    install(tagw(vp(1, 20), 0, 8'd1), frmw(19'h10, 3'b001), 40, "R5 set20 way0");
    install(tagw(vp(2, 20), 0, 8'd1), frmw(19'h20, 3'b001), 41, "R5 set20 way1");
    cmd(GETIDX); chk("R5 rr first", index_q, 32'd40);
    cmd(GETIDX); chk("R5 rr second", index_q, 32'd41);
    cmd(GETIDX); chk("R5 rr wrap", index_q, 32'd40);
  endtask

  task automatic t_erase();
    regw(2'd2, 32'd40); cmd(ERASE); cmd(READ);
    chk("R11 erased tag", tag_q, 0); chk("R11 erased frame", frame_q, 0);
    lookup(vp(1, 20), 8'd1, h, p, pm, o);
    chk("R11 erased miss", 32'(h), 0);
    regw(2'd0, tagw(vp(1, 20), 0, 8'd1)); cmd(GETIDX);
    chk("R5 free after erase", index_q, 32'd40);
    cmd(7); chk("R11 op7 no effect", index_q, 32'd40);
  endtask

  task automatic t_write_err();
    regw(2'd0, tagw(vp(4, 50), 0, 8'd1)); regw(2'd1, frmw(19'h55, 3'b111));
    cmd(PROBE); chk("R3 miss flag", index_q, 32'h8000_0000);
    cmd(WRITE);
    lookup(vp(4, 50), 8'd1, h, p, pm, o);
    chk("R6 write blocked by error", 32'(h), 0);
    cmd(GETIDX); chk("R6 set50 still free", index_q, 32'd100);
  endtask

  task automatic t_overlap();
    install(tagw(vp(5, 3), 0, 8'd5), frmw(19'h333, 3'b010), 7, "R5 dup slot");
    chk("R6 duplicate raises nothing", index_q, 32'd7);
    lookup(vp(5, 3), 8'd5, h, p, pm, o);
    chk("R10 overlap", 32'(o), 1); chk("R10 hit", 32'(h), 1);
    chk("R9 lowest way pfn", 32'(p), 32'h222);
    cmd(PROBE); chk("R3 lowest way", index_q, 32'd6);
  endtask

  task automatic t_same_cycle();
    regw(2'd2, 32'd6);
    @(negedge clk); cmd_valid = 1; cmd_op = ERASE;
    lk_req_valid = 1; lk_va = {vp(5, 3), 13'h0}; lk_asid = 8'd5; lk_rsp_ready = 1;
    @(negedge clk); cmd_valid = 0; lk_req_valid = 0;
    chk("R12 old view pfn", 32'(lk_rsp_pfn), 32'h222);
    chk("R12 old view overlap", 32'(lk_rsp_overlap), 1);
    lookup(vp(5, 3), 8'd5, h, p, pm, o);
    chk("R12 after erase pfn", 32'(p), 32'h333); chk("R10 single match", 32'(o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_regs(); t_install(); t_probe(); t_overwrite(); t_global();
    t_backpressure(); t_rr(); t_erase(); t_write_err(); t_overlap(); t_same_cycle();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule